// File: doc/BRIEF.md
# Address Register Write Hazard Interlock

This block sits in the decode stage of a small DSP core. It watches the instructions that leave decode and remembers which address-generation register each of them wrote: a pointer register R0 to R3, the stack pointer (SP), the offset register N or the modifier register (MOD). It also notes whether the write was a plain move or a bit-field operation. It then compares the register uses of the instruction now in decode against that history.

The block follows two policies. A plain move into N is interlocked in hardware. If the very next instruction reads N, the block raises a one-cycle stall request, and decode presents the same instruction again in the next cycle. Every other write becomes visible only to the second instruction after it. A use that comes too early is not stalled. The block raises a one-cycle sequence-violation flag and the instruction goes ahead with the old register value. A stack-pointer write followed at once by a load-effective-address or a pop is flagged in the same way.

Top module: `agu_wr_interlock`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties the write history. The first instruction after reset raises neither stall_req nor seq_viol, whatever uses it carries.
- R2: When the instruction just accepted was a plain move (wr_kind=0) to N (wr_tgt=6) and the instruction in decode has use_n=1, stall_req is high in its first decode cycle. In the next cycle, with the same instruction still presented, stall_req is low and the instruction is accepted.
- R3: A plain move to N causes no stall if the instruction after it does not use N. It also causes no stall for a use of N two or more instructions later.
- R4: A bit-field write (wr_kind=1) to N followed at once by an instruction with use_n=1 raises seq_viol for that instruction's cycle and does not raise stall_req.
- R5: A write of either kind to R0..R3 (wr_tgt=1..4), SP (5) or MOD (7) raises seq_viol when the next instruction sets the matching bit of use_addr (bit 0..3 for R0..R3, bit 4 for SP, bit 5 for MOD). A use two instructions after the write raises nothing.
- R6: A use of a register other than the one just written raises neither output.
- R7: After a write of either kind to SP, an immediately following instruction with lea_pop=1 raises seq_viol.
- R8: Only accepted instructions (instr_valid=1 and stall_req=0) advance the history. Cycles with instr_valid=0 leave the history unchanged and keep both outputs low.
- R9: The history holds during a stall cycle, so one move to N causes at most one stall. The stalled instruction's own write enters the history once, on acceptance. If that write is a plain move to N, it can stall the next instruction in turn.
- R10: stall_req and seq_viol are never high together, and seq_viol is high only in a cycle where an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is present in decode |
| wr_tgt | input | 3 | Register the instruction writes: 0 none, 1..4 R0..R3, 5 SP, 6 N, 7 MOD |
| wr_kind | input | 1 | Write kind: 0 plain move, 1 bit-field operation |
| use_addr | input | 6 | Address-register use mask: bits 0..3 R0..R3, bit 4 SP, bit 5 MOD |
| use_n | input | 1 | The instruction reads N |
| lea_pop | input | 1 | The instruction is a load-effective-address or a pop |
| stall_req | output | 1 | Stretch the previous write by one cycle; decode holds the instruction |
| seq_viol | output | 1 | The accepted instruction uses a register too early |

## Verification
The directed patterns pair each kind of write with a use at distance one and at distance two. This separates the interlocked move to N from the bit-field write to N, and the flagged too-early use from a legal later use. Separate patterns put a bubble between a write and its use, reset in the middle of a hazard, and issue back-to-back moves to N that also read N. These show whether the history advances per instruction or per cycle, and whether a stall holds it. A seeded random stream weighted toward N and SP mixes all write targets, write kinds and use masks. It shows whether rules interfere when several apply at once.

// File: rtl/agu_ilk_pkg.sv
// Package: shared types and helpers for the address-register write interlock.
// Assumes the 3-bit target code and 6-bit use mask layout given in the brief.
package agu_ilk_pkg;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_R0   = 3'd1,
        TGT_R1   = 3'd2,
        TGT_R2   = 3'd3,
        TGT_R3   = 3'd4,
        TGT_SP   = 3'd5,
        TGT_N    = 3'd6,
        TGT_MOD  = 3'd7
    } wr_tgt_e;

    typedef enum logic {
        KIND_MOVE = 1'b0,
        KIND_BITF = 1'b1
    } wr_kind_e;

    typedef struct packed {
        wr_tgt_e  tgt;
        wr_kind_e kind;
    } hist_ent_t;

    localparam int unsigned ADDR_USE_W = 6;
    localparam int unsigned SP_BIT     = 4;
    localparam int unsigned MOD_BIT    = 5;

    localparam hist_ent_t HIST_EMPTY = '{tgt: TGT_NONE, kind: KIND_MOVE};

    // Map a write target onto the bit it occupies in the address-use mask.
    function automatic logic [ADDR_USE_W-1:0] tgt_use_mask(input wr_tgt_e t);
        logic [ADDR_USE_W-1:0] m;
        m = '0;
        case (t)
            TGT_R0:  m[0] = 1'b1;
            TGT_R1:  m[1] = 1'b1;
            TGT_R2:  m[2] = 1'b1;
            TGT_R3:  m[3] = 1'b1;
            TGT_SP:  m[SP_BIT] = 1'b1;
            TGT_MOD: m[MOD_BIT] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/agu_ilk_history.sv
// Module: shift register of recent address-register writes, one entry per
// accepted instruction; entry 0 is the most recent.
// Assumes shift_en is high only when decode accepts an instruction.
module agu_ilk_history
    import agu_ilk_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  hist_ent_t             new_ent,
    output hist_ent_t [DEPTH-1:0] ent_q
);

    // Entry 0 captures the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q[0] <= HIST_EMPTY;
        end else if (shift_en) begin
            ent_q[0] <= new_ent;
        end
    end

    genvar gi;
    generate
        for (gi = 1; gi < DEPTH; gi++) begin : g_age
            // Older entries move one place per accepted instruction.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q[gi] <= HIST_EMPTY;
                end else if (shift_en) begin
                    ent_q[gi] <= ent_q[gi-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/agu_ilk_hazard.sv
// Module: purely combinational comparison of the decode instruction's uses
// against the write history.
// Assumes entry k was written k+1 instructions before the one in decode.
// A write of a given class is usable once its age reaches that class's lag.
module agu_ilk_hazard
    import agu_ilk_pkg::*;
#(
    parameter int unsigned DEPTH    = 2,
    parameter int unsigned LAG_PTR  = 2,
    parameter int unsigned LAG_NBF  = 2,
    parameter int unsigned LAG_SPOP = 2
) (
    input  hist_ent_t [DEPTH-1:0] ent_q,
    input  logic [ADDR_USE_W-1:0] use_addr,
    input  logic                  use_n,
    input  logic                  lea_pop,
    output logic                  n_move_hit,
    output logic                  early_use
);

    // The interlocked case: the last accepted instruction moved into N and N is read now.
    always_comb begin
        n_move_hit = (ent_q[0].tgt == TGT_N) && (ent_q[0].kind == KIND_MOVE) && use_n;
    end

    // The flagged cases: any entry younger than its class lag that the instruction touches.
    always_comb begin
        early_use = 1'b0;
        for (int k = 0; k < int'(DEPTH); k++) begin
            if ((ent_q[k].tgt == TGT_N) && (ent_q[k].kind == KIND_BITF) && use_n
                && (k + 1 < int'(LAG_NBF))) begin
                early_use = 1'b1;
            end
            if (((tgt_use_mask(ent_q[k].tgt) & use_addr) != '0)
                && (k + 1 < int'(LAG_PTR))) begin
                early_use = 1'b1;
            end
            if ((ent_q[k].tgt == TGT_SP) && lea_pop && (k + 1 < int'(LAG_SPOP))) begin
                early_use = 1'b1;
            end
        end
    end

endmodule

// File: rtl/agu_ilk_stall_ctl.sv
// Module: turns an N-move hit into a single stall pulse per write.
// Assumes decode presents the same instruction again after a stall cycle.
module agu_ilk_stall_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic n_move_hit,
    output logic stall_req,
    output logic accept
);

    logic held_q;

    // A stall is requested once; the held flag blocks a second request.
    always_comb begin
        stall_req = instr_valid && n_move_hit && !held_q;
        accept    = instr_valid && !stall_req;
    end

    // Remember that the current write has already cost its one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (stall_req) begin
            held_q <= 1'b1;
        end else if (instr_valid) begin
            held_q <= 1'b0;
        end
    end

endmodule

// File: rtl/agu_wr_interlock.sv
// Module: top of the address-register write interlock. It stalls one cycle
// for a plain move into N read by the next instruction, and flags other
// too-early uses.
// Assumes wr_tgt/wr_kind/use_* describe the instruction in decode and are
// held stable while stall_req is high.
module agu_wr_interlock
    import agu_ilk_pkg::*;
#(
    parameter int unsigned HIST_DEPTH = 2,
    parameter int unsigned LAG_PTR    = 2,
    parameter int unsigned LAG_NBF    = 2,
    parameter int unsigned LAG_SPOP   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [2:0]            wr_tgt,
    input  logic                  wr_kind,
    input  logic [ADDR_USE_W-1:0] use_addr,
    input  logic                  use_n,
    input  logic                  lea_pop,
    output logic                  stall_req,
    output logic                  seq_viol
);

    hist_ent_t [HIST_DEPTH-1:0] ent_q;
    hist_ent_t                  new_ent;
    logic                       n_move_hit;
    logic                       early_use;
    logic                       accept;

    // Pack the decode write into a history entry.
    always_comb begin
        new_ent.tgt  = wr_tgt_e'(wr_tgt);
        new_ent.kind = wr_kind_e'(wr_kind);
    end

    agu_ilk_history #(
        .DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .new_ent  (new_ent),
        .ent_q    (ent_q)
    );

    agu_ilk_hazard #(
        .DEPTH    (HIST_DEPTH),
        .LAG_PTR  (LAG_PTR),
        .LAG_NBF  (LAG_NBF),
        .LAG_SPOP (LAG_SPOP)
    ) u_haz (
        .ent_q      (ent_q),
        .use_addr   (use_addr),
        .use_n      (use_n),
        .lea_pop    (lea_pop),
        .n_move_hit (n_move_hit),
        .early_use  (early_use)
    );

    agu_ilk_stall_ctl u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .n_move_hit  (n_move_hit),
        .stall_req   (stall_req),
        .accept      (accept)
    );

    // Flag a too-early use only for the instruction actually accepted.
    always_comb begin
        seq_viol = accept && early_use;
    end

endmodule

// File: rtl/agu_wr_interlock_chk.sv
// Module: port-level assertion checker bound to agu_wr_interlock.
module agu_wr_interlock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [2:0] wr_tgt,
    input logic       wr_kind,
    input logic [5:0] use_addr,
    input logic       use_n,
    input logic       lea_pop,
    input logic       stall_req,
    input logic       seq_viol
);

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> !stall_req); // R2

    AST_STALL_NEEDS_N_USE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (instr_valid && use_n)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!stall_req && !seq_viol)); // R8

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_req && seq_viol)); // R10

    AST_BITF_N_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !stall_req && wr_tgt == 3'd6 && wr_kind) |=> !stall_req); // R4

    AST_ADDR_WR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !stall_req && wr_tgt != 3'd6) |=> !stall_req); // R5

endmodule

bind agu_wr_interlock agu_wr_interlock_chk u_chk (.*);

// File: tb/agu_wr_interlock_bench.sv
module agu_wr_interlock_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [2:0] wr_tgt = 3'd0;
    logic       wr_kind = 1'b0;
    logic [5:0] use_addr = 6'd0;
    logic       use_n = 1'b0;
    logic       lea_pop = 1'b0;
    logic       stall_req;
    logic       seq_viol;

    int total = 0;
    int bad = 0;

    // reference model state: last two accepted writes and the stall-held flag
    logic [2:0] m_tgt [2];
    logic       m_kind [2];
    logic       m_held;

    always #4 clk = ~clk;

    agu_wr_interlock u_agu_wr_interlock (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .wr_tgt(wr_tgt),
        .wr_kind(wr_kind), .use_addr(use_addr), .use_n(use_n), .lea_pop(lea_pop),
        .stall_req(stall_req), .seq_viol(seq_viol)
    );

    function automatic logic [5:0] mask_of(input logic [2:0] t);
        case (t)
            3'd1: return 6'b000001;
            3'd2: return 6'b000010;
            3'd3: return 6'b000100;
            3'd4: return 6'b001000;
            3'd5: return 6'b010000;
            3'd7: return 6'b100000;
            default: return 6'b000000;
        endcase
    endfunction

    // requirement-level expectation: too-early use relative to the last accepted write
    function automatic logic exp_early(input logic [5:0] um, input logic un, input logic lp);
        logic e;
        e = 1'b0;
        if (m_tgt[0] == 3'd6 && m_kind[0] && un) e = 1'b1;           // R4
        if ((mask_of(m_tgt[0]) & um) != 6'd0) e = 1'b1;              // R5
        if (m_tgt[0] == 3'd5 && lp) e = 1'b1;                        // R7
        return e;
    endfunction

    function automatic logic exp_stall(input logic un);
        return (m_tgt[0] == 3'd6) && !m_kind[0] && un && !m_held;    // R2
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_tgt[0] = 3'd0; m_tgt[1] = 3'd0;
        m_kind[0] = 1'b0; m_kind[1] = 1'b0;
        m_held = 1'b0;
    endtask

    // present one instruction, check each decode cycle until accepted
    task automatic issue(input logic [2:0] t, input logic k, input logic [5:0] um,
                         input logic un, input logic lp, input string req);
        logic es;
        logic ev;
        @(negedge clk);
        instr_valid = 1'b1; wr_tgt = t; wr_kind = k; use_addr = um; use_n = un; lea_pop = lp;
        #1;
        es = exp_stall(un);
        ev = !es && exp_early(um, un, lp);
        chk(stall_req, es, {req, " stall"});
        chk(seq_viol, ev, {req, " viol"});
        if (es) begin
            m_held = 1'b1;
            @(negedge clk);
            #1;
            ev = exp_early(um, un, lp);
            chk(stall_req, 1'b0, {req, " R9 second cycle stall"});
            chk(seq_viol, ev, {req, " R9 second cycle viol"});
        end
        @(posedge clk);
        m_tgt[1] = m_tgt[0]; m_kind[1] = m_kind[0];
        m_tgt[0] = t; m_kind[0] = k;
        m_held = 1'b0;
    endtask

    task automatic bubble(input string req);
        @(negedge clk);
        instr_valid = 1'b0;
        use_addr = 6'h3f; use_n = 1'b1; lea_pop = 1'b1;
        #1;
        chk(stall_req, 1'b0, {req, " bubble stall"});
        chk(seq_viol, 1'b0, {req, " bubble viol"});
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        model_clear();
        do_reset();

        // R1: history empty after reset
        issue(3'd0, 1'b0, 6'h3f, 1'b1, 1'b1, "R1 first after reset");
        // R1: reset in the middle of a pending hazard
        issue(3'd5, 1'b0, 6'd0, 1'b0, 1'b0, "R1 sp write");
        do_reset();
        issue(3'd0, 1'b0, 6'h10, 1'b1, 1'b1, "R1 use after reset");

        // R2 and R9: move N then use N, then a later use without stall
        issue(3'd6, 1'b0, 6'd0, 1'b0, 1'b0, "R2 move N");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R2 use N");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R9 use N again");

        // R3: no use next, use two later
        issue(3'd6, 1'b0, 6'd0, 1'b0, 1'b0, "R3 move N");
        issue(3'd0, 1'b0, 6'h01, 1'b0, 1'b0, "R3 no use");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R3 late use");

        // R4: bit-field write to N then use
        issue(3'd6, 1'b1, 6'd0, 1'b0, 1'b0, "R4 bitf N");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R4 early use");

        // R5: pointer and modifier writes
        issue(3'd3, 1'b0, 6'd0, 1'b0, 1'b0, "R5 move R2");
        issue(3'd0, 1'b0, 6'h04, 1'b0, 1'b0, "R5 early R2");
        issue(3'd7, 1'b1, 6'd0, 1'b0, 1'b0, "R5 bitf MOD");
        issue(3'd0, 1'b0, 6'h20, 1'b0, 1'b0, "R5 early MOD");
        issue(3'd2, 1'b0, 6'd0, 1'b0, 1'b0, "R5 move R1");
        issue(3'd0, 1'b0, 6'd0, 1'b0, 1'b0, "R5 gap");
        issue(3'd0, 1'b0, 6'h02, 1'b0, 1'b0, "R5 late R1");

        // R6: a different register
        issue(3'd1, 1'b0, 6'd0, 1'b0, 1'b0, "R6 move R0");
        issue(3'd0, 1'b0, 6'h08, 1'b1, 1'b1, "R6 use R3");

        // R7: SP write then pop
        issue(3'd5, 1'b1, 6'd0, 1'b0, 1'b0, "R7 bitf SP");
        issue(3'd0, 1'b0, 6'd0, 1'b0, 1'b1, "R7 pop");

        // R8: a bubble does not age the history
        issue(3'd6, 1'b0, 6'd0, 1'b0, 1'b0, "R8 move N");
        bubble("R8");
        bubble("R8");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R8 use N after bubbles");

        // R9: back-to-back moves to N that each read N
        issue(3'd6, 1'b0, 6'd0, 1'b0, 1'b0, "R9 move N a");
        issue(3'd6, 1'b0, 6'd0, 1'b1, 1'b0, "R9 move N b");
        issue(3'd0, 1'b0, 6'd0, 1'b1, 1'b0, "R9 use N c");

        // R10: seeded random stream weighted toward N and SP
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] t;
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            t = (r < 4) ? 3'd6 : (r < 6) ? 3'd5 : 3'($urandom_range(0, 7));
            if ($urandom_range(0, 9) == 0) bubble("R10 random");
            issue(t, 1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)) & 6'($urandom_range(0, 63)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), "R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule